// File: doc/BRIEF.md
# Power-up reset sequencing controller

This block produces the internal chip reset. It asserts the reset on a power-on pulse, on an external reset pin, or on a supply dip that lasts long enough. It keeps the reset asserted until a chain of timeouts has expired. The first is a power-up delay counted on a slow RC tick. In crystal or resonator oscillator modes, and only on the power-on path, an oscillator settling count on the main clock follows. When the PLL is enabled, a PLL lock delay on the RC tick follows that. The block does not model the comparator, the oscillator or the PLL. It sees only their digital flags, and every delay length is a parameter.

The controller runs on the main clock `clk`. The RC tick `rc_tick` is a one-cycle enable pulse that is synchronous to `clk`. `por_n` resets all flops asynchronously. The external pin and the supply-low flag are asynchronous and each passes through a synchronizer of `SYNC_STAGES` flops. The FSM has six states. IDLE_RESET waits for the pin to be released, then goes to BOR_HOLD if the supply is low, else to PWRT, else (timer bypassed) it takes the post-power-up exit. BOR_HOLD waits for the supply, then goes to PWRT or takes the post-power-up exit. PWRT goes to the post-power-up exit when its count ends and returns to BOR_HOLD if the supply dips. The post-power-up exit leads to OST on the power-on path in crystal modes and to RUN otherwise. OST goes to PLL_LOCK when the PLL is enabled, else to RUN. PLL_LOCK goes to RUN. OST, PLL_LOCK and RUN go to BOR_HOLD on a filtered brown-out. From every state, a low pin forces IDLE_RESET.

Top module: `rstseq_ctrl`

## Requirements
- R1: While `por_n` is low, `rst_out` is 1 and `rst_cause` is 2'b01 (power-on). After a power-on, `rst_out` stays 1 until the whole timeout chain has finished.
- R2: With `cfg_pwrt_off`=0 the power-up delay lasts `PWRT_TICKS` RC ticks. With `cfg_pwrt_off`=1 it is skipped.
- R3: After a power-on in a crystal mode (`cfg_osc_mode` 0 to 3), `OST_CYCLES` clock cycles are counted after the power-up delay. Modes 4 to 7 skip this count.
- R4: With `cfg_pll_en`=1 in a crystal mode, a delay of `PLL_TICKS` RC ticks follows the oscillator count. In other modes `cfg_pll_en` adds no delay.
- R5: In RUN, a supply-low pulse shorter than `TBOR_CYCLES` synchronized cycles leaves `rst_out` at 0.
- R6: A longer supply-low sets `rst_out`=1 and `rst_cause`=2'b10. The reset holds while the flag stays set. On release the power-up delay runs and reset ends without an oscillator count.
- R7: A supply-low during the power-up delay returns the controller to BOR_HOLD. The delay then restarts from zero after the flag clears.
- R8: With `cfg_bor_en`=0, `supply_low` has no effect on `rst_out`. Enabling brown-out does not enable the power-up delay: with `cfg_pwrt_off`=1, reset ends right after the supply recovers.
- R9: A low `ext_rst_n` sets `rst_out` within `SYNC_STAGES`+1 cycles and `rst_cause`=2'b11. On release the sequence restarts at the power-up delay without an oscillator count.
- R10: `por_n` going low sets `rst_out` at once, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main oscillator clock |
| por_n | input | 1 | Asynchronous active-low power-on pulse |
| rc_tick | input | 1 | One-cycle RC tick enable, synchronous to clk |
| ext_rst_n | input | 1 | Asynchronous active-low external reset pin |
| supply_low | input | 1 | Asynchronous brown-out comparator flag |
| cfg_pwrt_off | input | 1 | 1 bypasses the power-up delay |
| cfg_bor_en | input | 1 | 1 enables brown-out detection |
| cfg_osc_mode | input | 3 | Oscillator mode, 0 to 3 are crystal modes |
| cfg_pll_en | input | 1 | 1 adds the PLL lock delay |
| rst_out | output | 1 | Internal reset, active high |
| rst_cause | output | 2 | Last reset source: 01 power-on, 10 brown-out, 11 pin |

## Verification
Some properties are checked on every cycle. A low synchronized pin forces reset on the next cycle. A supply dip during the power-up delay or while held always lands in BOR_HOLD. PLL_LOCK is entered only from OST. The oscillator count occurs only after a power-on. A disabled brown-out keeps RUN. The timer never passes its limit, and a brown-out trip needs a preceding low cycle. The bench scenarios show the things a single-cycle property cannot. These are the total release latency for each oscillator and configuration mix, and the ignoring of short dips. They also cover the full restart of the power-up delay after a second dip and the reported cause after each kind of reset.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    typedef enum logic [2:0] {
        IDLE_RESET,
        BOR_HOLD,
        PWRT,
        OST,
        PLL_LOCK,
        RUN
    } seq_state_e;

    typedef enum logic [1:0] {
        CAUSE_NONE     = 2'b00,
        CAUSE_POWERON  = 2'b01,
        CAUSE_BROWNOUT = 2'b10,
        CAUSE_EXTPIN   = 2'b11
    } rst_cause_e;

    // Modes 0..3 drive a crystal or resonator; 4..7 use an external or RC clock.
    localparam logic [2:0] OSC_XTAL_LAST = 3'd3;

    function automatic logic osc_is_crystal(input logic [2:0] mode);
        return mode <= OSC_XTAL_LAST;
    endfunction

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign q = chain_q[STAGES-1];

    initial begin
        a_r9_stage_count: assert (STAGES >= 1);
    end
endmodule

// File: rtl/rstseq_bor_filter.sv
module rstseq_bor_filter #(
    parameter int TBOR_CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic low,
    output logic trip
);
    localparam int W = $clog2(TBOR_CYCLES + 1);

    logic [W-1:0] hold_q;

    // Saturating length of the current low stretch.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (!(en && low)) begin
            hold_q <= '0;
        end else if (hold_q != W'(TBOR_CYCLES)) begin
            hold_q <= hold_q + W'(1);
        end
    end

    assign trip = en && low && (hold_q == W'(TBOR_CYCLES));

    // R5: a trip is never caused by a single low cycle.
    a_r5_trip_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
        trip |-> ($past(low) && $past(en)));
endmodule

// File: rtl/rstseq_timer.sv
module rstseq_timer #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         step,
    input  logic [W-1:0] limit,
    output logic         done
);
    logic [W-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clear) begin
            count_q <= '0;
        end else if (step) begin
            count_q <= count_q + W'(1);
        end
    end

    assign done = step && (count_q == limit - W'(1));

    // R2: the shared counter stays below the limit of the running phase.
    a_r2_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (limit != '0) |-> (count_q < limit));
endmodule

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl
    import rstseq_pkg::*;
#(
    parameter int PWRT_TICKS  = 2048,
    parameter int OST_CYCLES  = 1024,
    parameter int PLL_TICKS   = 64,
    parameter int TBOR_CYCLES = 200,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       rc_tick,
    input  logic       ext_rst_n,
    input  logic       supply_low,
    input  logic       cfg_pwrt_off,
    input  logic       cfg_bor_en,
    input  logic [2:0] cfg_osc_mode,
    input  logic       cfg_pll_en,
    output logic       rst_out,
    output logic [1:0] rst_cause
);
    localparam int LONG_AB = (PWRT_TICKS > OST_CYCLES) ? PWRT_TICKS : OST_CYCLES;
    localparam int LONGEST = (LONG_AB > PLL_TICKS) ? LONG_AB : PLL_TICKS;
    localparam int CNT_W   = $clog2(LONGEST + 1);

    seq_state_e   state_q, state_nx, after_pwrt;
    rst_cause_e   cause_q;
    logic         rst_q;
    logic         por_path_q;
    logic         ext_s, low_s, bor_low, bor_trip;
    logic         tmr_clear, tmr_step, tmr_done;
    logic [CNT_W-1:0] tmr_limit;

    rstseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ext_sync (
        .clk(clk), .rst_n(por_n), .d(ext_rst_n), .q(ext_s)
    );

    rstseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_low_sync (
        .clk(clk), .rst_n(por_n), .d(supply_low), .q(low_s)
    );

    rstseq_bor_filter #(.TBOR_CYCLES(TBOR_CYCLES)) u_bor_filt (
        .clk(clk), .rst_n(por_n), .en(cfg_bor_en), .low(low_s), .trip(bor_trip)
    );

    rstseq_timer #(.W(CNT_W)) u_timer (
        .clk(clk), .rst_n(por_n), .clear(tmr_clear), .step(tmr_step),
        .limit(tmr_limit), .done(tmr_done)
    );

    assign bor_low = cfg_bor_en && low_s;

    // Phase that follows the power-up delay (or replaces it when bypassed).
    always_comb begin
        after_pwrt = (por_path_q && osc_is_crystal(cfg_osc_mode)) ? OST : RUN;
    end

    // Timer source and length per phase.
    always_comb begin
        tmr_limit = CNT_W'(1);
        tmr_step  = 1'b0;
        unique case (state_q)
            PWRT:     begin tmr_limit = CNT_W'(PWRT_TICKS); tmr_step = rc_tick; end
            OST:      begin tmr_limit = CNT_W'(OST_CYCLES); tmr_step = 1'b1;    end
            PLL_LOCK: begin tmr_limit = CNT_W'(PLL_TICKS);  tmr_step = rc_tick; end
            default:  begin tmr_limit = CNT_W'(1);          tmr_step = 1'b0;    end
        endcase
    end

    assign tmr_clear = (state_nx != state_q);

    always_comb begin
        state_nx = state_q;
        if (!ext_s) begin
            state_nx = IDLE_RESET;
        end else begin
            unique case (state_q)
                IDLE_RESET: begin
                    if (bor_low)            state_nx = BOR_HOLD;
                    else if (!cfg_pwrt_off) state_nx = PWRT;
                    else                    state_nx = after_pwrt;
                end
                BOR_HOLD: begin
                    if (!bor_low) state_nx = cfg_pwrt_off ? after_pwrt : PWRT;
                end
                PWRT: begin
                    if (bor_low)       state_nx = BOR_HOLD;
                    else if (tmr_done) state_nx = after_pwrt;
                end
                OST: begin
                    if (bor_trip)      state_nx = BOR_HOLD;
                    else if (tmr_done) state_nx = cfg_pll_en ? PLL_LOCK : RUN;
                end
                PLL_LOCK: begin
                    if (bor_trip)      state_nx = BOR_HOLD;
                    else if (tmr_done) state_nx = RUN;
                end
                RUN: begin
                    if (bor_trip) state_nx = BOR_HOLD;
                end
                default: state_nx = IDLE_RESET;
            endcase
        end
    end

    // State register and power-on path flag.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q    <= IDLE_RESET;
            por_path_q <= 1'b1;
        end else begin
            state_q <= state_nx;
            if (!ext_s || state_nx == BOR_HOLD || state_nx == RUN) begin
                por_path_q <= 1'b0;
            end
        end
    end

    // Outputs: registered reset and last cause.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            rst_q   <= 1'b1;
            cause_q <= CAUSE_POWERON;
        end else begin
            rst_q <= (state_nx != RUN);
            if (!ext_s && state_q != IDLE_RESET) begin
                cause_q <= CAUSE_EXTPIN;
            end else if (state_nx == BOR_HOLD && state_q != BOR_HOLD) begin
                cause_q <= CAUSE_BROWNOUT;
            end
        end
    end

    assign rst_out   = rst_q;
    assign rst_cause = cause_q;

    a_r9_pin_forces_reset: assert property (@(posedge clk) disable iff (!por_n)
        !ext_s |=> rst_out);

    a_r7_pwrt_dip_rearms: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == PWRT && cfg_bor_en && low_s && ext_s) |=> (state_q == BOR_HOLD));

    a_r6_hold_while_low: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == BOR_HOLD && cfg_bor_en && low_s && ext_s) |=> (state_q == BOR_HOLD && rst_out));

    a_r4_pll_after_ost: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == PLL_LOCK && $past(state_q) != PLL_LOCK) |-> ($past(state_q) == OST));

    a_r3_ost_only_poweron: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == OST) |-> (rst_cause == CAUSE_POWERON));

    a_r8_bor_off_keeps_run: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == RUN && !cfg_bor_en && ext_s) |=> !rst_out);
endmodule

// File: tb/rstseq_ctrl_tb_top.sv
module rstseq_ctrl_tb_top;

    localparam int PW    = 8;
    localparam int OS    = 16;
    localparam int PL    = 4;
    localparam int TB    = 6;
    localparam int RCDIV = 4;
    localparam int TOL   = 6;

    // tag[17:15], osc[14:12], pll[11], pwrt_off[10], expected release cycles[9:0]
    localparam int NVEC = 7;
    localparam logic [17:0] VEC [0:NVEC-1] = '{
        {3'd3, 3'd1, 1'b0, 1'b0, 10'd49},
        {3'd3, 3'd0, 1'b0, 1'b0, 10'd49},
        {3'd4, 3'd3, 1'b1, 1'b0, 10'd65},
        {3'd2, 3'd4, 1'b0, 1'b0, 10'd33},
        {3'd2, 3'd4, 1'b0, 1'b1, 10'd1},
        {3'd3, 3'd2, 1'b0, 1'b1, 10'd17},
        {3'd4, 3'd6, 1'b1, 1'b0, 10'd33}
    };

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       rc_tick = 1'b0;
    logic       ext_rst_n = 1'b1;
    logic       supply_low = 1'b0;
    logic       cfg_pwrt_off = 1'b0;
    logic       cfg_bor_en = 1'b1;
    logic [2:0] cfg_osc_mode = 3'd4;
    logic       cfg_pll_en = 1'b0;
    logic       rst_out;
    logic [1:0] rst_cause;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int rc_cnt = 0;

    always #4 clk = ~clk;

    rstseq_ctrl #(
        .PWRT_TICKS(PW), .OST_CYCLES(OS), .PLL_TICKS(PL),
        .TBOR_CYCLES(TB), .SYNC_STAGES(2)
    ) dut_i (
        .clk(clk), .por_n(por_n), .rc_tick(rc_tick), .ext_rst_n(ext_rst_n),
        .supply_low(supply_low), .cfg_pwrt_off(cfg_pwrt_off), .cfg_bor_en(cfg_bor_en),
        .cfg_osc_mode(cfg_osc_mode), .cfg_pll_en(cfg_pll_en),
        .rst_out(rst_out), .rst_cause(rst_cause)
    );

    always @(negedge clk) begin
        rc_cnt  <= (rc_cnt + 1) % RCDIV;
        rc_tick <= (rc_cnt == RCDIV - 1);
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            total = total + 1;
            bad   = bad + 1;
            $display("FAIL watchdog: got cycle %0d exp completion", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0d exp %0d", tag, got, exp);
        end
    endtask

    task automatic check_win(input string tag, input int got, input int lo, input int hi);
        total++;
        if (got < lo || got > hi) begin
            bad++;
            $display("FAIL %s: got %0d exp %0d..%0d", tag, got, lo, hi);
        end
    endtask

    task automatic cycles(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic wait_release(output int n);
        n = 0;
        while (rst_out === 1'b1 && n < 400) begin
            @(negedge clk);
            n++;
        end
    endtask

    function automatic string tname(input int t);
        case (t)
            2: return "R2";
            3: return "R3";
            default: return "R4";
        endcase
    endfunction

    initial begin
        int n;
        int highs;
        cycles(2);

        // Table walk: one power-on sequence per configuration.
        for (int v = 0; v < NVEC; v++) begin
            por_n        = 1'b0;
            ext_rst_n    = 1'b1;
            supply_low   = 1'b0;
            cfg_osc_mode = VEC[v][14:12];
            cfg_pll_en   = VEC[v][11];
            cfg_pwrt_off = VEC[v][10];
            cycles(3);
            check("R1 reset during por", int'(rst_out), 1);
            check("R1 cause power-on", int'(rst_cause), 1);
            por_n = 1'b1;
            wait_release(n);
            check_win(tname(int'(VEC[v][17:15])), n,
                      int'(VEC[v][9:0]) - TOL, int'(VEC[v][9:0]) + TOL);
            check("R1 cause kept", int'(rst_cause), 1);
        end

        // Directed: start from a plain power-on in a non-crystal mode.
        por_n = 1'b0; cfg_osc_mode = 3'd4; cfg_pll_en = 1'b0; cfg_pwrt_off = 1'b0;
        cycles(3);
        por_n = 1'b1;
        wait_release(n);
        cycles(4);

        // R5: short dip is filtered.
        supply_low = 1'b1; cycles(3); supply_low = 1'b0;
        cycles(12);
        check("R5 short dip ignored", int'(rst_out), 0);

        // R6: long dip, crystal mode, no oscillator count on recovery.
        cfg_osc_mode = 3'd1;
        supply_low = 1'b1;
        cycles(15);
        check("R6 reset on long dip", int'(rst_out), 1);
        check("R6 cause brown-out", int'(rst_cause), 2);
        cycles(10);
        check("R6 held while low", int'(rst_out), 1);
        supply_low = 1'b0;
        wait_release(n);
        check_win("R6 release latency", n, 35 - TOL, 35 + TOL);

        // R7: second dip inside the power-up delay restarts it.
        cycles(4);
        supply_low = 1'b1; cycles(15); supply_low = 1'b0;
        cycles(16);
        check("R7 still in delay", int'(rst_out), 1);
        supply_low = 1'b1; cycles(3); supply_low = 1'b0;
        wait_release(n);
        check_win("R7 full restart", n, 35 - TOL, 35 + TOL);
        check("R7 cause brown-out", int'(rst_cause), 2);

        // R8: disabled detection ignores the flag.
        cycles(4);
        cfg_bor_en = 1'b0;
        supply_low = 1'b1;
        highs = 0;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (rst_out) highs++;
        end
        check("R8 bor disabled", highs, 0);
        supply_low = 1'b0;
        cycles(4);
        cfg_bor_en = 1'b1;

        // R8: brown-out enable alone does not add the power-up delay.
        cfg_pwrt_off = 1'b1;
        supply_low = 1'b1; cycles(15);
        check("R8 reset on dip", int'(rst_out), 1);
        supply_low = 1'b0;
        wait_release(n);
        check_win("R8 no delay when bypassed", n, 1, 6);
        cfg_pwrt_off = 1'b0;

        // R9: external pin.
        cycles(4);
        ext_rst_n = 1'b0;
        cycles(3);
        check("R9 pin asserts reset", int'(rst_out), 1);
        check("R9 cause pin", int'(rst_cause), 3);
        cycles(10);
        ext_rst_n = 1'b1;
        wait_release(n);
        check_win("R9 restart without osc count", n, 35 - TOL, 35 + TOL);
        check("R9 cause kept", int'(rst_cause), 3);

        // R10: asynchronous power-on assertion between edges.
        cycles(4);
        @(negedge clk);
        #2 por_n = 1'b0;
        #1;
        check("R10 async reset", int'(rst_out), 1);
        check("R10 cause power-on", int'(rst_cause), 1);
        @(negedge clk);
        por_n = 1'b1;
        wait_release(n);
        check_win("R3 power-on crystal", n, 49 - TOL, 49 + TOL);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule